// File: doc/BRIEF.md
# Write Guard and Status Byte Unit

This unit sits behind the command decoder of a serial nonvolatile memory slave. It holds the write enable latch and three persistent protection bits: a two-bit block-protect level and a pin-lock enable. It judges every array or status write request against the write-protect pin, the pin-lock enable, the latch and the protected address range, and it answers each request with a one-cycle grant flag. When the host deselects the slave after a granted write, a commit pulse starts a self-timed write cycle. The cycle length is set by a cycle-count parameter. While that cycle runs the unit reports busy and ignores every command.

The status byte goes to the serial front end as plain data. When idle it carries the pin-lock enable in bit 7, the protect level in bits 3 and 2, the latch in bit 1, busy in bit 0, and zeros elsewhere. During a write cycle it reads as all ones. A status write takes effect when its cycle completes. A falling protect pin before the commit can cancel a pending status write. Once the cycle has started, the pin no longer matters.

Top module: `guard_status_unit`

## Requirements
- R1: After reset the status byte is 0x00, busy is 0 and the grant flag is 0.
- R2: A latch-set strobe sets status bit 1. A latch-clear strobe clears it whatever the level of the protect pin.
- R3: When idle, status bit 7 is the pin-lock enable, bits 3 and 2 are the protect level (bit 3 the upper bit), bit 1 is the latch, and bits 6 to 4 and bit 0 are 0.
- R4: A commit pulse that follows a granted write raises busy in the next cycle. Busy then stays high for exactly WRITE_CYCLES cycles, and the status byte reads 0xFF throughout.
- R5: When a write cycle completes, the write enable latch is cleared.
- R6: Protect level 00 protects no address. Level 01 protects the top quarter (both address MSBs 1). Level 10 protects the top half (address MSB 1). Level 11 protects every address. An array write request to a protected address is never granted, and one to an unprotected address is granted when the latch is set.
- R7: With the latch clear, no write request is granted, and a following commit starts no write cycle.
- R8: When the protect pin is low and the pin-lock enable is 1, status write requests are refused. Array writes to unprotected addresses are still granted.
- R9: A status write copies only data bits 7, 3 and 2 into the pin-lock enable and the protect level, and it does so when its cycle completes. Every other data bit is ignored.
- R10: If the protect pin is low while select is low, the pin-lock enable is 1 and a status write is pending, the write is cancelled and the commit starts no cycle. A protect pin falling during a running cycle does not stop it.
- R11: While busy, latch strobes and write requests are ignored and no grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Slave select, low while a transaction is open |
| wp_n | input | 1 | Write-protect pin, low asserts protection |
| wen_set | input | 1 | Decoded latch-set strobe |
| wen_clr | input | 1 | Decoded latch-clear strobe |
| stat_wr | input | 1 | Status write request strobe |
| arr_wr | input | 1 | Array write request strobe |
| req_addr | input | ADDR_W | Target address of an array write |
| stat_wdata | input | 8 | Data byte of a status write |
| commit | input | 1 | Write-commit pulse at deselect |
| allow | output | 1 | Grant for the request of the previous cycle |
| busy | output | 1 | Self-timed write cycle running |
| status | output | 8 | Status byte for the serial front end |

## Verification
On every cycle the assertions check three things: the status byte reads all ones under busy and has its reserved bits at zero when idle, a completed cycle leaves the latch clear, and no grant follows a request that a clear latch, full-array protection, hardware lock or busy forbids. Some behaviour spans whole transactions and only the bench scenarios can show it. That covers the exact busy duration, the deferred update of the protection bits, and a status write cancelled by the pin before commit. It also covers the pin having no effect once a cycle runs, and the address boundary of each protect level.

// File: rtl/guard_pkg.sv
package guard_pkg;
    typedef enum logic [1:0] {
        LVL_OPEN    = 2'b00,
        LVL_QUARTER = 2'b01,
        LVL_HALF    = 2'b10,
        LVL_FULL    = 2'b11
    } prot_lvl_e;

    // Status bits that a status write may change: lock enable and protect level.
    localparam logic [7:0] NV_KEEP_MASK = 8'b1000_1100;
    localparam int         LOCK_BIT     = 7;
    localparam int         LVL_HI_BIT   = 3;
    localparam int         LVL_LO_BIT   = 2;
    localparam int         LATCH_BIT    = 1;
    localparam logic [7:0] BUSY_BYTE    = 8'hFF;
endpackage

// File: rtl/guard_prot_dec.sv
module guard_prot_dec
    import guard_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  prot_lvl_e          lvl,
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit
);
    localparam int TOP = ADDR_W - 1;

    logic upper_half;
    logic upper_quarter;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign upper_half    = addr[TOP];
            assign upper_quarter = addr[TOP] & addr[TOP-1];
        end else begin : g_narrow
            assign upper_half    = addr[TOP];
            assign upper_quarter = addr[TOP];
        end
    endgenerate

    always_comb begin
        unique case (lvl)
            LVL_OPEN:    hit = 1'b0;
            LVL_QUARTER: hit = upper_quarter;
            LVL_HALF:    hit = upper_half;
            default:     hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/guard_cycle_timer.sv
module guard_cycle_timer #(
    parameter int CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start && cnt_q == '0) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/guard_status_unit.sv
module guard_status_unit
    import guard_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int WRITE_CYCLES = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wp_n,
    input  logic              wen_set,
    input  logic              wen_clr,
    input  logic              stat_wr,
    input  logic              arr_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        stat_wdata,
    input  logic              commit,
    output logic              allow,
    output logic              busy,
    output logic [7:0]        status
);
    typedef struct packed {
        logic       latch;
        logic [7:0] nv;
        logic [7:0] nv_new;
        logic       pend_stat;
        logic       pend_arr;
        logic       cyc_stat;
        logic       allow;
    } unit_t;

    unit_t     st_d, st_q;
    logic      start_cyc;
    logic      cyc_done;
    logic      hw_lock;
    logic      addr_hit;
    logic      cancel;
    prot_lvl_e cur_lvl;

    assign cur_lvl = prot_lvl_e'({st_q.nv[LVL_HI_BIT], st_q.nv[LVL_LO_BIT]});
    assign hw_lock = ~wp_n & st_q.nv[LOCK_BIT];
    assign cancel  = st_q.pend_stat & ~sel_n & hw_lock;

    guard_prot_dec #(.ADDR_W(ADDR_W)) u_dec (
        .lvl  (cur_lvl),
        .addr (req_addr),
        .hit  (addr_hit)
    );

    guard_cycle_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_cyc),
        .busy  (busy),
        .done  (cyc_done)
    );

    always_comb begin
        st_d       = st_q;
        st_d.allow = 1'b0;
        start_cyc  = 1'b0;
        if (cyc_done) begin
            st_d.latch    = 1'b0;
            st_d.cyc_stat = 1'b0;
            if (st_q.cyc_stat) st_d.nv = st_q.nv_new;
        end else if (!busy) begin
            if (wen_set) st_d.latch = 1'b1;
            if (wen_clr) st_d.latch = 1'b0;
            if (stat_wr && st_q.latch && !hw_lock) begin
                st_d.pend_stat = 1'b1;
                st_d.nv_new    = stat_wdata & NV_KEEP_MASK;
                st_d.allow     = 1'b1;
            end
            if (arr_wr && st_q.latch && !addr_hit) begin
                st_d.pend_arr = 1'b1;
                st_d.allow    = 1'b1;
            end
            if (cancel) st_d.pend_stat = 1'b0;
            if (commit) begin
                start_cyc      = (st_q.pend_stat && !cancel) || st_q.pend_arr;
                st_d.cyc_stat  = st_q.pend_stat && !cancel;
                st_d.pend_stat = 1'b0;
                st_d.pend_arr  = 1'b0;
            end else if (sel_n) begin
                st_d.pend_stat = 1'b0;
                st_d.pend_arr  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign allow  = st_q.allow;
    assign status = busy ? BUSY_BYTE
                         : ((st_q.nv & NV_KEEP_MASK) | (8'(st_q.latch) << LATCH_BIT));
endmodule

// File: rtl/guard_status_chk.sv
module guard_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n,
    input logic       wen_clr,
    input logic       stat_wr,
    input logic       arr_wr,
    input logic       commit,
    input logic       allow,
    input logic       busy,
    input logic [7:0] status
);
    // R4
    busy_reads_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> status == 8'hFF);

    // R3
    idle_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (status[6:4] == 3'b000 && !status[0]));

    // R5
    latch_cleared_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !status[1]);

    // R2
    latch_clear_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_clr && !busy && !commit) |=> !status[1]);

    // R7
    no_grant_without_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_wr || arr_wr) && !busy && !status[1]) |=> !allow);

    // R6
    full_array_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr && !stat_wr && !busy && status[3:2] == 2'b11) |=> !allow);

    // R8
    hw_lock_blocks_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !arr_wr && !busy && !wp_n && status[7]) |=> !allow);

    // R11
    no_grant_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!allow || !$past(busy)));
endmodule

bind guard_status_unit guard_status_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wp_n    (wp_n),
    .wen_clr (wen_clr),
    .stat_wr (stat_wr),
    .arr_wr  (arr_wr),
    .commit  (commit),
    .allow   (allow),
    .busy    (busy),
    .status  (status)
);

// File: tb/guard_status_unit_test.sv
module guard_status_unit_test;
    localparam int AW = 8;
    localparam int WC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          wp_n = 1'b1;
    logic          wen_set = 1'b0;
    logic          wen_clr = 1'b0;
    logic          stat_wr = 1'b0;
    logic          arr_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    stat_wdata = '0;
    logic          commit = 1'b0;
    logic          allow;
    logic          busy;
    logic [7:0]    status;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    guard_status_unit #(.ADDR_W(AW), .WRITE_CYCLES(WC)) uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wp_n(wp_n),
        .wen_set(wen_set), .wen_clr(wen_clr), .stat_wr(stat_wr), .arr_wr(arr_wr),
        .req_addr(req_addr), .stat_wdata(stat_wdata), .commit(commit),
        .allow(allow), .busy(busy), .status(status)
    );

    // entry: {protect level[1:0], address[7:0], expected grant}
    localparam logic [10:0] VEC [12] = '{
        {2'b00, 8'h00, 1'b1}, {2'b00, 8'hFF, 1'b1},
        {2'b01, 8'hBF, 1'b1}, {2'b01, 8'hC0, 1'b0},
        {2'b01, 8'hFF, 1'b0}, {2'b01, 8'h00, 1'b1},
        {2'b10, 8'h7F, 1'b1}, {2'b10, 8'h80, 1'b0},
        {2'b10, 8'hC5, 1'b0}, {2'b11, 8'h00, 1'b0},
        {2'b11, 8'h55, 1'b0}, {2'b11, 8'hFF, 1'b0}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_latch();
        sel_n = 1'b0; wen_set = 1'b1; step();
        wen_set = 1'b0; sel_n = 1'b1; step();
    endtask

    task automatic prog_status(input logic [7:0] d);
        set_latch();
        sel_n = 1'b0; stat_wr = 1'b1; stat_wdata = d; step();
        stat_wr = 1'b0; commit = 1'b1; sel_n = 1'b1; step();
        commit = 1'b0;
        repeat (WC + 2) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] cur_lvl;
        repeat (3) step();
        chk("R1 status", status, 8'h00);
        chk("R1 busy", busy, 1'b0);
        chk("R1 allow", allow, 1'b0);
        rst_n = 1'b1;
        step();

        // R2 latch set, R3 layout
        set_latch();
        chk("R2 latch set", status, 8'h02);

        // R9 / R4 status write with all data bits set
        sel_n = 1'b0; stat_wr = 1'b1; stat_wdata = 8'hFF; step();
        stat_wr = 1'b0;
        chk("R9 status grant", allow, 1'b1);
        chk("R9 not applied before cycle", status, 8'h02);
        commit = 1'b1; sel_n = 1'b1; step();
        commit = 1'b0;
        chk("R4 busy raised", busy, 1'b1);
        chk("R4 all ones", status, 8'hFF);
        repeat (WC - 1) step();
        chk("R4 busy last cycle", busy, 1'b1);
        step();
        chk("R4 busy ends", busy, 1'b0);
        chk("R9 R3 R5 status after", status, 8'h8C);

        // R6 table of protect levels and addresses
        cur_lvl = 2'b11;
        foreach (VEC[i]) begin
            if (VEC[i][10:9] != cur_lvl) begin
                prog_status({4'b0000, VEC[i][10:9], 2'b00});
                cur_lvl = VEC[i][10:9];
            end
            set_latch();
            sel_n = 1'b0; arr_wr = 1'b1; req_addr = VEC[i][8:1]; step();
            arr_wr = 1'b0;
            chk($sformatf("R6 lvl=%0d addr=%0h", VEC[i][10:9], VEC[i][8:1]), allow, VEC[i][0]);
            sel_n = 1'b1; step();
        end

        // R8 hardware lock
        prog_status(8'h80);
        chk("R3 lock only", status, 8'h80);
        wp_n = 1'b0;
        set_latch();
        sel_n = 1'b0; stat_wr = 1'b1; stat_wdata = 8'h0C; step();
        stat_wr = 1'b0;
        chk("R8 status refused", allow, 1'b0);
        commit = 1'b1; sel_n = 1'b1; step();
        commit = 1'b0;
        chk("R8 no cycle", busy, 1'b0);
        sel_n = 1'b0; arr_wr = 1'b1; req_addr = 8'hFF; step();
        arr_wr = 1'b0;
        chk("R8 array still granted", allow, 1'b1);
        sel_n = 1'b1; step();
        wp_n = 1'b1; step();

        // R10 cancel before commit
        sel_n = 1'b0; stat_wr = 1'b1; stat_wdata = 8'h84; step();
        stat_wr = 1'b0;
        chk("R10 armed", allow, 1'b1);
        wp_n = 1'b0; step();
        commit = 1'b1; sel_n = 1'b1; step();
        commit = 1'b0;
        chk("R10 cancelled no cycle", busy, 1'b0);
        chk("R10 bits unchanged", status, 8'h82);
        wp_n = 1'b1; step();

        // R10 pin during running cycle, R11 busy ignores requests
        sel_n = 1'b0; stat_wr = 1'b1; stat_wdata = 8'h84; step();
        stat_wr = 1'b0; commit = 1'b1; sel_n = 1'b1; step();
        commit = 1'b0;
        chk("R10 cycle started", busy, 1'b1);
        wp_n = 1'b0;
        sel_n = 1'b0; wen_set = 1'b1; arr_wr = 1'b1; req_addr = 8'h00; step();
        wen_set = 1'b0; arr_wr = 1'b0;
        chk("R11 no grant when busy", allow, 1'b0);
        sel_n = 1'b1;
        repeat (WC + 2) step();
        chk("R10 R11 applied despite pin", status, 8'h84);

        // R2 clear under low pin
        set_latch();
        chk("R2 latch set again", status, 8'h86);
        sel_n = 1'b0; wen_clr = 1'b1; step();
        wen_clr = 1'b0; sel_n = 1'b1;
        chk("R2 clear with pin low", status, 8'h84);
        wp_n = 1'b1; step();

        // R7 latch clear refuses writes
        sel_n = 1'b0; arr_wr = 1'b1; req_addr = 8'h00; step();
        arr_wr = 1'b0;
        chk("R7 no grant", allow, 1'b0);
        commit = 1'b1; sel_n = 1'b1; step();
        commit = 1'b0;
        chk("R7 no cycle", busy, 1'b0);

        // R5 latch cleared after array write
        set_latch();
        sel_n = 1'b0; arr_wr = 1'b1; req_addr = 8'h10; step();
        arr_wr = 1'b0;
        chk("R5 granted", allow, 1'b1);
        commit = 1'b1; sel_n = 1'b1; step();
        commit = 1'b0;
        chk("R5 busy", busy, 1'b1);
        repeat (WC + 2) step();
        chk("R5 latch cleared", status, 8'h84);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule